// File: doc/BRIEF.md
# Isochronous/Asynchronous Bus Cycle Scheduler

This block decides which node of a shared serial bus may transmit, and when. A root timer divides time into fixed cycles of `CYCLE_TICKS` clocks; the nominal cycle is 125 microseconds, so the default counts that span at a 50 MHz clock, and a bench can pass a short value. Every cycle opens with a one-clock `cycle_start` strobe. After the strobe, nodes that raised an isochronous request are served first and nodes with asynchronous requests follow. Within each class the node with the lowest index is the one closest to the root, so it wins. The others that have not yet been served get the bus in turn, in index order.

Isochronous grants may only begin during the first `ISO_PCT` percent of the cycle (80 by default). The remaining share of the cycle stays available to asynchronous traffic. A node gets at most one grant of each kind per cycle. A granted node keeps the bus until it pulses its own `done` line. A transfer that runs past the end of the cycle postpones the next strobe until that pulse arrives.

The controller has three states. START drives the strobe and clears the per-node served flags. ARB looks for an eligible requester. BUSY holds the grant. The transitions are:
- START to ARB, always.
- ARB to START when the timer is at its last tick.
- ARB to BUSY when a requester is eligible.
- ARB stays in ARB when no requester is eligible.
- BUSY to ARB on the holder's done pulse before the cycle end.
- BUSY to START on that pulse at or after the cycle end.
- BUSY stays in BUSY otherwise.

Top module: `isoc_cycle_sched`

## Requirements
- R1: While reset is high and in the clock after it is released, `grant` is all-zero and `cycle_start` is high. Reset clears all served flags, so every node is eligible again.
- R2: `cycle_start` is high for exactly one clock. When no transfer overruns, it recurs every `CYCLE_TICKS` clocks. `grant` is zero while `cycle_start` is high.
- R3: `grant` is one-hot or all-zero. The first grant of a cycle appears 2 clocks after the clock in which `cycle_start` is high.
- R4: No asynchronous grant (`grant_iso` = 0) is issued while a node has an unserved isochronous request and the isochronous window is open.
- R5: Among eligible requesters of the same kind, the node with the lowest index is granted (bit i of `grant` is node i).
- R6: Each node gets at most one isochronous and one asynchronous grant per cycle. Unserved requesters are granted one after another until all have been served.
- R7: Call the clock with `cycle_start` high clock 0. An isochronous grant is decided only while the elapsed count is below `CYCLE_TICKS*ISO_PCT/100`, so it becomes visible no later than that clock. A request arriving later waits for the next cycle, and asynchronous requests are still granted meanwhile.
- R8: `grant` falls in the clock after the holder's `done` bit is sampled high. A `done` pulse from any other node has no effect.
- R9: `grant_iso` holds its value for the whole tenure of a grant (1 = isochronous, 0 = asynchronous).
- R10: No grant is decided on the last tick of a cycle. If a transfer is still running at the cycle end, the next `cycle_start` is delayed and appears in the same clock in which the grant falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iso_req | input | N_NODES | Per-node isochronous request level |
| asy_req | input | N_NODES | Per-node asynchronous request level |
| done | input | N_NODES | Per-node end-of-transfer pulse |
| grant | output | N_NODES | One-hot bus grant, all-zero when idle |
| grant_iso | output | 1 | 1 while the current grant is isochronous |
| cycle_start | output | 1 | One-clock strobe opening each cycle |

## Verification
Every result is registered, so its timing is fixed:
- A request sampled at a clock edge while the scheduler is arbitrating shows up as a grant at that edge.
- A grant is therefore visible 2 clocks after the strobe.
- A grant falls 1 clock after the done pulse, and the next grant is 1 clock after that.
- The strobe recurs `CYCLE_TICKS` clocks later.

The bench drives inputs on the falling edge and keeps a tick index counted from the strobe. It places requests just before and just after the isochronous cutoff and the cycle end, and samples on the falling edge of exactly the clock in which each result is due.

// File: rtl/isoc_sched_pkg.sv
package isoc_sched_pkg;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_ARB   = 2'd1,
        ST_BUSY  = 2'd2
    } sched_state_t;

endpackage

// File: rtl/isoc_cycle_timer.sv
module isoc_cycle_timer #(
    parameter int CYCLE_TICKS = 6250,
    parameter int ISO_PCT     = 80,
    localparam int CW         = $clog2(CYCLE_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    output logic [CW-1:0] tick,
    output logic          at_end,
    output logic          iso_open
);

    localparam int            ISO_LIMIT = (CYCLE_TICKS * ISO_PCT) / 100;
    localparam logic [CW-1:0] END_T     = CW'(CYCLE_TICKS - 1);
    localparam logic [CW-1:0] ISO_T     = CW'(ISO_LIMIT);

    // Elapsed clocks since the strobe; saturates at the last tick.
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tick <= '0;
        end else if (tick != END_T) begin
            tick <= tick + 1'b1;
        end
    end

    assign at_end   = (tick == END_T);
    assign iso_open = (tick < ISO_T);

    // R2
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        tick <= END_T);

endmodule

// File: rtl/isoc_prio_pick.sv
module isoc_prio_pick #(
    parameter int N_NODES = 4
) (
    input  logic [N_NODES-1:0] req,
    output logic [N_NODES-1:0] hot,
    output logic               any
);

    // Lowest index (nearest the root) wins.
    for (genvar gi = 0; gi < N_NODES; gi++) begin : g_bit
        if (gi == 0) begin : g_first
            assign hot[gi] = req[gi];
        end else begin : g_rest
            assign hot[gi] = req[gi] & ~(|req[gi-1:0]);
        end
    end

    assign any = |req;

endmodule

// File: rtl/isoc_cycle_sched.sv
module isoc_cycle_sched #(
    parameter int N_NODES     = 4,
    parameter int CYCLE_TICKS = 6250,
    parameter int ISO_PCT     = 80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_NODES-1:0] iso_req,
    input  logic [N_NODES-1:0] asy_req,
    input  logic [N_NODES-1:0] done,
    output logic [N_NODES-1:0] grant,
    output logic               grant_iso,
    output logic               cycle_start
);
    import isoc_sched_pkg::*;

    localparam int            CW        = $clog2(CYCLE_TICKS + 1);
    localparam int            ISO_LIMIT = (CYCLE_TICKS * ISO_PCT) / 100;
    localparam logic [CW-1:0] ISO_T     = CW'(ISO_LIMIT);

    sched_state_t       state, state_nx;
    logic [CW-1:0]      tick;
    logic               at_end, iso_open, restart;
    logic [N_NODES-1:0] iso_srv, asy_srv;
    logic [N_NODES-1:0] iso_pend, asy_pend, iso_hot, asy_hot, pick_vec;
    logic               iso_any, asy_any, iso_take, pick_any, done_hit;

    isoc_cycle_timer #(
        .CYCLE_TICKS(CYCLE_TICKS),
        .ISO_PCT    (ISO_PCT)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .at_end  (at_end),
        .iso_open(iso_open)
    );

    assign iso_pend = iso_req & ~iso_srv;
    assign asy_pend = asy_req & ~asy_srv;

    isoc_prio_pick #(.N_NODES(N_NODES)) u_pick_iso (
        .req(iso_pend), .hot(iso_hot), .any(iso_any)
    );

    isoc_prio_pick #(.N_NODES(N_NODES)) u_pick_asy (
        .req(asy_pend), .hot(asy_hot), .any(asy_any)
    );

    assign iso_take = iso_any & iso_open;
    assign pick_vec = iso_take ? iso_hot : asy_hot;
    assign pick_any = iso_take | asy_any;
    assign done_hit = |(grant & done);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_START;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_START: state_nx = ST_ARB;
            ST_ARB: begin
                if (at_end) begin
                    state_nx = ST_START;
                end else if (pick_any) begin
                    state_nx = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (done_hit) begin
                    state_nx = at_end ? ST_START : ST_ARB;
                end
            end
            default: state_nx = ST_START;
        endcase
    end

    assign restart     = (state_nx == ST_START);
    assign cycle_start = (state == ST_START);

    // Registered outputs and served flags
    always_ff @(posedge clk) begin
        if (rst) begin
            grant     <= '0;
            grant_iso <= 1'b0;
            iso_srv   <= '0;
            asy_srv   <= '0;
        end else begin
            unique case (state)
                ST_START: begin
                    grant     <= '0;
                    grant_iso <= 1'b0;
                    iso_srv   <= '0;
                    asy_srv   <= '0;
                end
                ST_ARB: begin
                    if (!at_end && pick_any) begin
                        grant     <= pick_vec;
                        grant_iso <= iso_take;
                        if (iso_take) begin
                            iso_srv <= iso_srv | pick_vec;
                        end else begin
                            asy_srv <= asy_srv | pick_vec;
                        end
                    end
                end
                ST_BUSY: begin
                    if (done_hit) begin
                        grant     <= '0;
                        grant_iso <= 1'b0;
                    end
                end
                default: begin
                    grant     <= '0;
                    grant_iso <= 1'b0;
                end
            endcase
        end
    end

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R2
    start_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_start |-> (grant == '0));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

    // R7
    iso_cutoff_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(|grant) && grant_iso) |-> ($past(tick) < ISO_T));

    // R4
    iso_first_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(|grant) && !grant_iso) |-> $past(!(|iso_pend) || (tick >= ISO_T)));

    // R6
    iso_once_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(|grant) && grant_iso) |-> (($past(iso_srv) & grant) == '0));

    // R9
    kind_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((|grant) && ($past(grant) == grant)) |-> $stable(grant_iso));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (|(grant & done)) |=> (grant == '0));

    // R8
    foreign_done_chk: assert property (@(posedge clk) disable iff (rst)
        ((|grant) && !(|(grant & done))) |=> (grant == $past(grant)));

endmodule

// File: tb/test_isoc_cycle_sched.sv
module test_isoc_cycle_sched;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int CT         = 40;
    localparam int IPCT       = 80;
    localparam int ILIM       = (CT * IPCT) / 100;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] iso_req = '0;
    logic [N-1:0] asy_req = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] grant;
    logic         grant_iso;
    logic         cycle_start;

    int checks   = 0;
    int failures = 0;
    int k        = 0;
    int cyc      = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    isoc_cycle_sched #(
        .N_NODES(N), .CYCLE_TICKS(CT), .ISO_PCT(IPCT)
    ) i_isoc_cycle_sched (
        .clk(clk), .rst(rst), .iso_req(iso_req), .asy_req(asy_req),
        .done(done), .grant(grant), .grant_iso(grant_iso),
        .cycle_start(cycle_start)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog cycles=%0d expected<=%0d", cyc, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (tick %0d)", tag, act, exp, k);
        end
    endtask

    task automatic step();
        @(negedge clk);
        k++;
    endtask

    task automatic wait_strobe();
        step();
        for (int n = 0; n < 200 && !cycle_start; n++) step();
        k = 0;
    endtask

    task automatic step_to(input int t);
        while (k < t) step();
    endtask

    // Wait for a grant, check it, hold it, then release it with done.
    task automatic serve(input int idx, input bit iso, input int hold,
                         input string tag, output int seen_k);
        for (int n = 0; n < 100 && grant == '0; n++) step();
        seen_k = k;
        chk(grant == N'(1 << idx) && grant_iso == iso, tag,
            {grant, 3'b0, grant_iso}, {N'(1 << idx), 3'b0, iso});
        for (int h = 0; h < hold; h++) begin
            step();
            chk(grant_iso == iso && grant == N'(1 << idx), "R9 kind held",
                {grant, 3'b0, grant_iso}, {N'(1 << idx), 3'b0, iso});
        end
        done[idx] = 1'b1;
        step();
        done = '0;
        chk(grant == '0, "R8 grant falls after done", grant, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cycle_start && grant == '0, "R1 reset state", {grant, cycle_start}, 1);
        rst = 1'b0;
        k = 0;
        step();
        chk(!cycle_start && grant == '0, "R1 after release", {grant, cycle_start}, 0);
    endtask

    task automatic t_period();
        int n;
        int sk;
        wait_strobe();
        chk(grant == '0, "R2 no grant at strobe", grant, 0);
        step();
        chk(!cycle_start, "R2 strobe one clock", cycle_start, 0);
        n = 1;
        while (!cycle_start && n < 100) begin
            step();
            n++;
        end
        chk(n == CT, "R2 cycle period", n, CT);
        k = 0;
        step_to(CT - 1);
        asy_req = 4'b0010;
        step();
        chk(cycle_start && grant == '0, "R10 no grant on last tick", {grant, cycle_start}, 1);
        k = 0;
        serve(1, 1'b0, 0, "R10 deferred grant", sk);
        chk(sk == 2, "R3 grant two clocks after strobe", sk, 2);
        asy_req = '0;
    endtask

    task automatic t_order();
        int sk;
        bit extra;
        wait_strobe();
        iso_req = 4'b1010;
        asy_req = 4'b0101;
        step();
        chk(grant == '0, "R3 no grant one clock after strobe", grant, 0);
        serve(1, 1'b1, 3, "R5 lowest iso node first", sk);
        chk(sk == 2, "R3 first grant timing", sk, 2);
        serve(3, 1'b1, 0, "R6 next iso in turn", sk);
        serve(0, 1'b0, 0, "R4 async after all iso", sk);
        serve(2, 1'b0, 0, "R6 next async in turn", sk);
        extra = 1'b0;
        while (!cycle_start && k < 100) begin
            step();
            if (!cycle_start && grant != '0) extra = 1'b1;
        end
        chk(!extra, "R6 no second grant in cycle", extra, 0);
        iso_req = '0;
        asy_req = '0;
        k = 0;
    endtask

    task automatic t_foreign_done();
        int sk;
        wait_strobe();
        asy_req = 4'b0001;
        step();
        step();
        chk(grant == 4'b0001, "R5 single async", grant, 1);
        done = 4'b0100;
        step();
        done = '0;
        chk(grant == 4'b0001, "R8 foreign done ignored", grant, 1);
        serve(0, 1'b0, 0, "R8 own done", sk);
        asy_req = '0;
    endtask

    task automatic t_cutoff();
        int sk;
        bit leak;
        wait_strobe();
        step_to(ILIM - 1);
        iso_req = 4'b0001;
        step();
        chk(grant == 4'b0001 && grant_iso, "R7 last iso slot", {grant, 3'b0, grant_iso}, 9'h11);
        done = 4'b0001;
        iso_req = '0;
        step();
        done = '0;
        chk(grant == '0, "R8 release after iso", grant, 0);

        wait_strobe();
        step_to(ILIM);
        iso_req = 4'b0100;
        asy_req = 4'b0010;
        step();
        chk(grant == 4'b0010 && !grant_iso, "R7 async after cutoff", {grant, 3'b0, grant_iso}, 9'h20);
        done = 4'b0010;
        asy_req = '0;
        step();
        done = '0;
        leak = 1'b0;
        while (!cycle_start && k < 100) begin
            step();
            if (!cycle_start && grant != '0) leak = 1'b1;
        end
        chk(!leak, "R7 iso held past cutoff", leak, 0);
        k = 0;
        serve(2, 1'b1, 0, "R7 iso served next cycle", sk);
        chk(sk == 2, "R7 deferred iso timing", sk, 2);
        iso_req = '0;
    endtask

    task automatic t_overrun();
        bit bad;
        wait_strobe();
        step_to(CT - 5);
        asy_req = 4'b1000;
        step();
        chk(grant == 4'b1000 && !grant_iso, "R10 late grant", {grant, 3'b0, grant_iso}, 9'h80);
        bad = 1'b0;
        while (k < CT + 10) begin
            step();
            if (grant != 4'b1000 || grant_iso || cycle_start) bad = 1'b1;
        end
        chk(!bad, "R10 strobe delayed, R9 kind held", bad, 0);
        done = 4'b1000;
        asy_req = '0;
        step();
        done = '0;
        chk(cycle_start && grant == '0, "R10 strobe with grant drop", {grant, cycle_start}, 1);
    endtask

    initial begin
        t_reset();
        t_period();
        t_order();
        t_foreign_done();
        t_cutoff();
        t_overrun();
        t_reset();
        repeat (2) step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule